// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block is a pin controller for a bank of ports, 12 ports of 16 pins each by default. Software drives it over a plain synchronous register bus with an address, write data, a write strobe and read data. For every pin it can select plain port mode or one of eight alternate peripheral functions. It also sets the pin direction, whether the pin's input buffer is on, whether the input path stays open while the pin is driven, and whether the peripheral or software decides the direction in alternate mode.

Each control register is 16 bits wide and covers one port, and bit n of a register belongs to pin n of that port. The global pin number g sits in port g/16 at bit g%16. The pad, peripheral and alternate-function vectors are flat and indexed by global pin. The alternate vectors carry eight entries per pin at index g*8+function.

Each pad input passes through a two-flop synchronizer. The synchronized level feeds both the level readback register and the input seen by peripherals. When the relevant input path is closed, that value is 0.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset every pin is an undriven input and every pad output enable is 0. Every direction register reads 0xFFFF, and every mode, function, input-buffer, bidirectional and peripheral-direction register reads 0. The level readback reads 0 and every peripheral input is 0, whatever the pad levels are.
- R2: A register sits at its bank offset plus port*4. The bank offsets are: output data 0x0000, level readback 0x0200, direction 0x0300, mode 0x0400, function bit0 0x0500, function bit1 0x0600, function bit2 0x0A00, input buffer 0x4000, bidirectional 0x4100 and peripheral direction 0x4200. A write takes effect at the clock edge where the strobe is sampled. Read data appears one cycle after the address is presented.
- R3: In port mode (mode bit 0), a pin whose direction bit is 0 drives its output enable to 1 and drives its pad output from its output data bit. A pin whose direction bit is 1 has its output enable at 0.
- R4: In alternate mode (mode bit 1), the pad output is the alternate output at index {bit2,bit1,bit0}, taken from the three function registers, with function bit0 as the least significant bit.
- R5: In alternate mode, a peripheral-direction bit of 1 makes the output enable follow the selected function's output enable. A peripheral-direction bit of 0 makes the output enable the inverse of the direction bit.
- R6: The level readback bit of a pin is its synchronized pad level when the input buffer bit is 1 and the pin is either not driven or has its bidirectional bit at 1. Otherwise the bit is 0. A pad change reaches the readback two clock edges after it is applied.
- R7: The peripheral input of a pin is its synchronized pad level when the pin is in alternate mode and is either not driven or has its bidirectional bit at 1. Otherwise it is 0, including at all times in port mode.
- R8: The level readback register is read-only, and writes to it change nothing. Reads of addresses that decode to no bank, or to ports 12 to 15, return 0. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 15 | Register byte address |
| busWdata | input | 16 | Register write data |
| busWe | input | 1 | Write strobe |
| busRdata | output | 16 | Registered read data |
| padIn | input | 192 | Pad input level per global pin |
| altOut | input | 1536 | Alternate-function output values, index pin*8+function |
| altOe | input | 1536 | Alternate-function output enables, index pin*8+function |
| padOut | output | 192 | Pad output value per pin |
| padOe | output | 192 | Pad output enable per pin |
| periphIn | output | 192 | Synchronized input level routed to peripherals |

## Verification
The hardest case to reach is the readback of a pin's own driven level. It needs the pin set as an output, the input buffer on, the bidirectional path opened last, and a pad level that differs from the output data, all held for two synchronizer edges. The stimulus first reads the same configuration with the bidirectional bit cleared and expects 0, then sets the bit and expects the pad pattern. Alternate selection is exercised by driving a different value at two function indices of one pin and switching the index between them through the three function registers.

// File: rtl/gpio_mux_pkg.sv
`timescale 1ns/1ps
package gpio_mux_pkg;

  parameter int REG_W      = 16;
  parameter int FUNC_W     = 3;
  parameter int NUM_FUNCS  = 1 << FUNC_W;
  parameter int PORT_SEL_W = 4;
  parameter int ADDR_W     = 15;

  typedef enum logic [3:0] {
    BK_DATA, BK_LEVEL, BK_DIR, BK_MODE, BK_FN0, BK_FN1, BK_FN2,
    BK_IBUF, BK_BIDIR, BK_PDIR, BK_NONE
  } bank_e;

  typedef struct packed {
    logic                  wr;
    logic                  rdHit;
    bank_e                 bank;
    logic [PORT_SEL_W-1:0] port;
    logic [REG_W-1:0]      data;
  } bus_strobe_t;

  function automatic bank_e decodeBank(input logic [6:0] hi);
    case (hi)
      7'h00:   return BK_DATA;
      7'h02:   return BK_LEVEL;
      7'h03:   return BK_DIR;
      7'h04:   return BK_MODE;
      7'h05:   return BK_FN0;
      7'h06:   return BK_FN1;
      7'h0A:   return BK_FN2;
      7'h40:   return BK_IBUF;
      7'h41:   return BK_BIDIR;
      7'h42:   return BK_PDIR;
      default: return BK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_mux_regif.sv
`timescale 1ns/1ps
module gpio_mux_regif
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PORTS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              busWe,
  output bus_strobe_t       strobe
);

  localparam logic [PORT_SEL_W:0] PORT_LIM = NUM_PORTS[PORT_SEL_W:0];

  bank_e                 bankSel;
  logic [PORT_SEL_W-1:0] portSel;
  logic                  portOk;
  logic                  hit;

  always_comb begin
    bankSel = decodeBank(busAddr[14:8]);
    portSel = busAddr[5:2];
    portOk  = ({1'b0, portSel} < PORT_LIM) && (busAddr[7:6] == 2'b00)
              && (busAddr[1:0] == 2'b00);
    hit     = (bankSel != BK_NONE) && portOk;
  end

  always_comb begin
    strobe.bank  = bankSel;
    strobe.port  = portSel;
    strobe.data  = busWdata;
    strobe.rdHit = hit;
    strobe.wr    = busWe && hit && (bankSel != BK_LEVEL);
  end

  AST_LEVEL_RO: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wr |-> strobe.bank != BK_LEVEL); // R8

  AST_WR_PORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wr |-> ({1'b0, busAddr[5:2]} < PORT_LIM)); // R8

endmodule

// File: rtl/gpio_mux_pin_cell.sv
`timescale 1ns/1ps
module gpio_mux_pin_cell
  import gpio_mux_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 outBit,
  input  logic                 dirBit,
  input  logic                 modeBit,
  input  logic [FUNC_W-1:0]    fnIdx,
  input  logic                 ibufBit,
  input  logic                 bidirBit,
  input  logic                 pdirBit,
  input  logic                 padIn,
  input  logic [NUM_FUNCS-1:0] altOutVec,
  input  logic [NUM_FUNCS-1:0] altOeVec,
  output logic                 padOut,
  output logic                 padOe,
  output logic                 periphIn,
  output logic                 levelBit
);

  logic [1:0] syncQ;
  logic       padSync;
  logic       altO;
  logic       altE;
  logic       pathOpen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= 2'b00;
    else        syncQ <= {syncQ[0], padIn};
  end

  assign padSync = syncQ[1];

  always_comb begin
    altO     = altOutVec[fnIdx];
    altE     = altOeVec[fnIdx];
    padOut   = modeBit ? altO : outBit;
    padOe    = (modeBit && pdirBit) ? altE : ~dirBit;
    pathOpen = ~padOe | bidirBit;
    levelBit = padSync & ibufBit & pathOpen;
    periphIn = padSync & modeBit & pathOpen;
  end

  AST_SYNC_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
    (modeBit && pathOpen && $past(modeBit && pathOpen) && $past(modeBit && pathOpen, 2))
    |-> periphIn == $past(padIn, 2)); // R7

  AST_SYNC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ibufBit && pathOpen && $past(ibufBit && pathOpen) && $past(ibufBit && pathOpen, 2))
    |-> levelBit == $past(padIn, 2)); // R6

endmodule

// File: rtl/gpio_mux_datapath.sv
`timescale 1ns/1ps
module gpio_mux_datapath
  import gpio_mux_pkg::*;
#(
  parameter  int NUM_PORTS = 12,
  localparam int NUM_PINS  = NUM_PORTS * REG_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  bus_strobe_t                   strobe,
  input  logic [NUM_PINS-1:0]           padIn,
  input  logic [NUM_PINS*NUM_FUNCS-1:0] altOut,
  input  logic [NUM_PINS*NUM_FUNCS-1:0] altOe,
  output logic [NUM_PINS-1:0]           padOut,
  output logic [NUM_PINS-1:0]           padOe,
  output logic [NUM_PINS-1:0]           periphIn,
  output logic [REG_W-1:0]              busRdata
);

  logic [REG_W-1:0] regData  [NUM_PORTS];
  logic [REG_W-1:0] regDir   [NUM_PORTS];
  logic [REG_W-1:0] regMode  [NUM_PORTS];
  logic [REG_W-1:0] regFn0   [NUM_PORTS];
  logic [REG_W-1:0] regFn1   [NUM_PORTS];
  logic [REG_W-1:0] regFn2   [NUM_PORTS];
  logic [REG_W-1:0] regIbuf  [NUM_PORTS];
  logic [REG_W-1:0] regBidir [NUM_PORTS];
  logic [REG_W-1:0] regPdir  [NUM_PORTS];
  logic [NUM_PINS-1:0] levelFlat;
  logic [REG_W-1:0]    rdSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        regData[p]  <= '0;
        regDir[p]   <= '1;
        regMode[p]  <= '0;
        regFn0[p]   <= '0;
        regFn1[p]   <= '0;
        regFn2[p]   <= '0;
        regIbuf[p]  <= '0;
        regBidir[p] <= '0;
        regPdir[p]  <= '0;
      end
    end else if (strobe.wr) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (strobe.port == PORT_SEL_W'(p)) begin
          case (strobe.bank)
            BK_DATA:  regData[p]  <= strobe.data;
            BK_DIR:   regDir[p]   <= strobe.data;
            BK_MODE:  regMode[p]  <= strobe.data;
            BK_FN0:   regFn0[p]   <= strobe.data;
            BK_FN1:   regFn1[p]   <= strobe.data;
            BK_FN2:   regFn2[p]   <= strobe.data;
            BK_IBUF:  regIbuf[p]  <= strobe.data;
            BK_BIDIR: regBidir[p] <= strobe.data;
            BK_PDIR:  regPdir[p]  <= strobe.data;
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar b = 0; b < REG_W; b++) begin : g_pin
      localparam int G = p * REG_W + b;
      gpio_mux_pin_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .outBit    (regData[p][b]),
        .dirBit    (regDir[p][b]),
        .modeBit   (regMode[p][b]),
        .fnIdx     ({regFn2[p][b], regFn1[p][b], regFn0[p][b]}),
        .ibufBit   (regIbuf[p][b]),
        .bidirBit  (regBidir[p][b]),
        .pdirBit   (regPdir[p][b]),
        .padIn     (padIn[G]),
        .altOutVec (altOut[G*NUM_FUNCS +: NUM_FUNCS]),
        .altOeVec  (altOe[G*NUM_FUNCS +: NUM_FUNCS]),
        .padOut    (padOut[G]),
        .padOe     (padOe[G]),
        .periphIn  (periphIn[G]),
        .levelBit  (levelFlat[G])
      );
    end
  end

  always_comb begin
    rdSel = '0;
    if (strobe.rdHit) begin
      case (strobe.bank)
        BK_DATA:  rdSel = regData[strobe.port];
        BK_LEVEL: rdSel = levelFlat[strobe.port*REG_W +: REG_W];
        BK_DIR:   rdSel = regDir[strobe.port];
        BK_MODE:  rdSel = regMode[strobe.port];
        BK_FN0:   rdSel = regFn0[strobe.port];
        BK_FN1:   rdSel = regFn1[strobe.port];
        BK_FN2:   rdSel = regFn2[strobe.port];
        BK_IBUF:  rdSel = regIbuf[strobe.port];
        BK_BIDIR: rdSel = regBidir[strobe.port];
        BK_PDIR:  rdSel = regPdir[strobe.port];
        default:  rdSel = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busRdata <= '0;
    else        busRdata <= rdSel;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.rdHit |=> busRdata == '0); // R8

  AST_RESET_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (padOe == '0 && periphIn == '0)); // R1

endmodule

// File: rtl/gpio_mux_ctrl.sv
`timescale 1ns/1ps
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter  int NUM_PORTS = 12,
  localparam int NUM_PINS  = NUM_PORTS * REG_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [REG_W-1:0]              busWdata,
  input  logic                          busWe,
  output logic [REG_W-1:0]              busRdata,
  input  logic [NUM_PINS-1:0]           padIn,
  input  logic [NUM_PINS*NUM_FUNCS-1:0] altOut,
  input  logic [NUM_PINS*NUM_FUNCS-1:0] altOe,
  output logic [NUM_PINS-1:0]           padOut,
  output logic [NUM_PINS-1:0]           padOe,
  output logic [NUM_PINS-1:0]           periphIn
);

  bus_strobe_t strobe;

  gpio_mux_regif #(.NUM_PORTS(NUM_PORTS)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busWe    (busWe),
    .strobe   (strobe)
  );

  gpio_mux_datapath #(.NUM_PORTS(NUM_PORTS)) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .padIn    (padIn),
    .altOut   (altOut),
    .altOe    (altOe),
    .padOut   (padOut),
    .padOe    (padOe),
    .periphIn (periphIn),
    .busRdata (busRdata)
  );

endmodule

// File: tb/gpio_mux_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_mux_ctrl_bench;
  import gpio_mux_pkg::*;

  localparam int NP   = 12;
  localparam int NPIN = NP * REG_W;
  localparam int PIN  = 53;            // port 3, bit 5
  localparam int ABASE = PIN * NUM_FUNCS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0]        busAddr = '0;
  logic [REG_W-1:0]         busWdata = '0;
  logic                     busWe = 1'b0;
  logic [REG_W-1:0]         busRdata;
  logic [NPIN-1:0]          padIn = '0;
  logic [NPIN*NUM_FUNCS-1:0] altOut = '0;
  logic [NPIN*NUM_FUNCS-1:0] altOe = '0;
  logic [NPIN-1:0]          padOut;
  logic [NPIN-1:0]          padOe;
  logic [NPIN-1:0]          periphIn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_mux_ctrl #(.NUM_PORTS(NP)) u_gpio_mux_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .padIn(padIn), .altOut(altOut),
    .altOe(altOe), .padOut(padOut), .padOe(padOe), .periphIn(periphIn)
  );

  // {address, write data, expected read}
  localparam logic [46:0] VEC [0:6] = '{
    {15'h0000, 16'hA5A5, 16'hA5A5},   // R2 data port 0
    {15'h032C, 16'h1234, 16'h1234},   // R2 direction port 11
    {15'h0A08, 16'h00F0, 16'h00F0},   // R2 function bit2 port 2
    {15'h4104, 16'h8001, 16'h8001},   // R2 bidirectional port 1
    {15'h0200, 16'hFFFF, 16'h0000},   // R8 level register read-only
    {15'h0030, 16'hFFFF, 16'h0000},   // R8 port 12 unmapped
    {15'h0700, 16'hBEEF, 16'h0000}    // R8 bank gap unmapped
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    @(negedge clk);
    d = busRdata;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [REG_W-1:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 output enables", {31'b0, |padOe}, 32'd0);
    chk("R1 peripheral inputs", {31'b0, |periphIn}, 32'd0);
    rd(15'h0314, v); chk("R1 direction port5", {16'b0, v}, 32'h0000FFFF);
    rd(15'h0414, v); chk("R1 mode port5", {16'b0, v}, 32'h0);
    rd(15'h4014, v); chk("R1 input buffer port5", {16'b0, v}, 32'h0);
    padIn = '1;
    idle(3);
    rd(15'h0200, v); chk("R1 level hidden", {16'b0, v}, 32'h0);
    chk("R1 peripheral hidden", {31'b0, |periphIn}, 32'd0);
    padIn = '0;

    // register vectors
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][46:32], VEC[i][31:16]);
      rd(VEC[i][46:32], v);
      chk($sformatf("R2/R8 vector %0d", i), {16'b0, v}, {16'b0, VEC[i][15:0]});
    end
    rd(15'h0000, v); chk("R8 port12 write no alias", {16'b0, v}, 32'h0000A5A5);

    // R3 port mode output
    wr(15'h4104, 16'h0000);
    wr(15'h0304, 16'h0000);
    wr(15'h0004, 16'h00FF);
    chk("R3 pad out port1", {16'b0, padOut[31:16]}, 32'h000000FF);
    chk("R3 pad oe port1", {16'b0, padOe[31:16]}, 32'h0000FFFF);
    chk("R7 port mode peripheral 0", {16'b0, periphIn[31:16]}, 32'h0);

    // R6 readback of driven pins
    wr(15'h4004, 16'hFFFF);
    padIn[31:16] = 16'h3C3C;
    idle(3);
    rd(15'h0204, v); chk("R6 driven no bidir", {16'b0, v}, 32'h0);
    wr(15'h4104, 16'hFFFF);
    rd(15'h0204, v); chk("R6 driven with bidir", {16'b0, v}, 32'h00003C3C);

    // R6 input pins and synchronizer delay
    wr(15'h4008, 16'h0F0F);
    padIn[47:32] = 16'hFFFF;
    idle(3);
    rd(15'h0208, v); chk("R6 input buffer mask", {16'b0, v}, 32'h00000F0F);
    @(negedge clk);
    padIn[47:32] = 16'h0000;
    busAddr = 15'h0208;
    @(negedge clk);
    chk("R6 sync delay old level", {16'b0, busRdata}, 32'h00000F0F);
    idle(2);
    rd(15'h0208, v); chk("R6 sync new level", {16'b0, v}, 32'h0);
    wr(15'h0208, 16'h0000);
    padIn[47:32] = 16'hFFFF;
    idle(3);
    rd(15'h0208, v); chk("R8 level write ignored", {16'b0, v}, 32'h00000F0F);

    // R4 R5 alternate mode on pin 53
    wr(15'h040C, 16'h0020);
    wr(15'h050C, 16'h0020);
    wr(15'h0A0C, 16'h0020);
    wr(15'h420C, 16'h0020);
    @(negedge clk);
    altOut[ABASE+5] = 1'b1; altOe[ABASE+5] = 1'b1;
    @(negedge clk);
    chk("R4 function 5 out", {31'b0, padOut[PIN]}, 32'd1);
    chk("R5 peripheral oe high", {31'b0, padOe[PIN]}, 32'd1);
    chk("R7 driven no bidir", {31'b0, periphIn[PIN]}, 32'd0);
    altOe[ABASE+5] = 1'b0;
    @(negedge clk);
    chk("R5 peripheral oe low", {31'b0, padOe[PIN]}, 32'd0);
    wr(15'h050C, 16'h0000);
    wr(15'h0A0C, 16'h0000);
    wr(15'h060C, 16'h0020);
    chk("R4 function 2 out 0", {31'b0, padOut[PIN]}, 32'd0);
    altOut[ABASE+2] = 1'b1; altOe[ABASE+2] = 1'b1;
    @(negedge clk);
    chk("R4 function 2 out 1", {31'b0, padOut[PIN]}, 32'd1);
    chk("R5 function 2 oe", {31'b0, padOe[PIN]}, 32'd1);
    wr(15'h420C, 16'h0000);
    chk("R5 software dir input", {31'b0, padOe[PIN]}, 32'd0);
    wr(15'h030C, 16'hFFDF);
    chk("R5 software dir output", {31'b0, padOe[PIN]}, 32'd1);

    // R7 peripheral input
    padIn[PIN] = 1'b1;
    idle(3);
    chk("R7 driven pin closed", {31'b0, periphIn[PIN]}, 32'd0);
    wr(15'h410C, 16'h0020);
    chk("R7 driven with bidir", {31'b0, periphIn[PIN]}, 32'd1);
    wr(15'h030C, 16'hFFFF);
    padIn[PIN] = 1'b0;
    idle(3);
    chk("R7 undriven follows pad", {31'b0, periphIn[PIN]}, 32'd0);

    done = 1'b1;
    finishRun();
  end

endmodule